// File: doc/BRIEF.md
# Character Display Parallel Host Port

This block is the target side of the parallel microprocessor port on a character-display controller. A host drives a strobe, a register-select line, a read/write line and an 8-bit data bus. All of these come from outside the system clock domain. The block resynchronises them, detects the end of each bus cycle on the strobe's falling edge, and turns completed writes into a single-cycle, byte-wide write strobe. That strobe carries a tag naming the target: the instruction register or the data register.

On reads the block turns on its bus drivers while the strobe is high. On the register-select-low side it returns the busy flag on bit 7 with the 7-bit address counter under it. On the register-select-high side it returns the data-register contents. A completed data read emits a one-cycle read request, so that the address counter outside the block can step.

A mode input chooses full-byte transfers or nibble transfers. In nibble mode every byte takes two strobe cycles on the upper four lines, high half first, then low half.

Top module: `lcd_host_port`

## Requirements
- R1: While rst_ni is low, and after its release until a bus cycle ends, wr_valid_o, rd_req_o, db_oe_o, db_o, wr_sel_o and wr_byte_o are all 0.
- R2: In byte mode (mode4_i=0), a bus cycle with rnw_i=0 produces exactly one wr_valid_o pulse. The pulse is visible after the third rising clk_i edge that samples strobe_i low. wr_byte_o then equals db_i as sampled on the last edge that saw strobe_i high.
- R3: wr_sel_o equals rsel_i of the completing cycle: 0 means the instruction register, 1 means the data register.
- R4: db_oe_o is high only while the synchronised strobe is high together with rnw_i=1. It rises after the second edge that samples both high, and falls after the second edge that samples strobe_i low.
- R5: While db_oe_o is high in byte mode, db_o is {busy_i, addr_ctr_i[6:0]} when rsel_i=0, and rd_data_i when rsel_i=1.
- R6: A completed read with rsel_i=1 gives one rd_req_o pulse with the same latency as R2. A read with rsel_i=0 gives none. wr_valid_o and rd_req_o are never high together.
- R7: In nibble mode (mode4_i=1), only db_i[7:4] is used and db_i[3:0] is ignored. The first cycle supplies byte bits 7..4 and the second supplies bits 3..0. wr_valid_o fires only after the second cycle, with wr_sel_o taken from that second cycle.
- R8: In nibble mode a read drives the selected source's bits 7..4 on db_o[7:4] in the first phase and bits 3..0 in the second phase, with db_o[3:0]=0. rd_req_o follows only the second phase.
- R9: On a clock edge where mode4_i differs from the registered mode, the nibble phase returns to the first phase. A bus cycle that completes on that same edge is dropped: it produces no wr_valid_o and no rd_req_o.
- R10: db_o is 0 whenever db_oe_o is low.
- R11: wr_byte_o and wr_sel_o change only together with a wr_valid_o pulse. Reads leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode4_i | input | 1 | 1 = nibble transfers, 0 = byte transfers |
| strobe_i | input | 1 | Host bus-cycle strobe, asynchronous |
| rsel_i | input | 1 | Register select: 0 instruction side, 1 data side |
| rnw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| db_i | input | 8 | Data bus as seen at the pads |
| db_o | output | 8 | Data driven onto the bus |
| db_oe_o | output | 1 | Bus driver enable |
| busy_i | input | 1 | Internal operation in progress |
| addr_ctr_i | input | 7 | Current address counter |
| rd_data_i | input | 8 | Data-register read value |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_sel_o | output | 1 | Target of the write: 0 instruction, 1 data |
| wr_byte_o | output | 8 | Assembled write byte |
| rd_req_o | output | 1 | One-cycle data-read request |

## Verification
A mode change and the completion of a bus cycle can fall on the same clock edge. In that case the phase reset and the write or read-request output compete. The bench provokes this by flipping mode4_i exactly two clock cycles after it drops the strobe, once during a nibble-mode write and once during a byte-mode write. The reference model expects the transfer to be dropped and the phase to restart. This is judged by the missing pulse on that edge and by the nibble order of the reads that follow.

// File: rtl/lcd_hif_pkg.sv
package lcd_hif_pkg;
  typedef enum logic {
    SEL_INSTR = 1'b0,
    SEL_DATA  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic strobe;
    logic rsel;
    logic rnw;
  } bus_ctl_t;
endpackage

// File: rtl/lcd_hif_pipe.sv
module lcd_hif_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/lcd_hif_xfer.sv
module lcd_hif_xfer #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode4_i,
  input  logic              fall_i,
  input  logic              rnw_i,
  input  logic              rsel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mode_q_o,
  output logic              phase_o,
  output logic              wr_valid_o,
  output logic              wr_sel_o,
  output logic [DATA_W-1:0] wr_byte_o,
  output logic              rd_req_o
);
  localparam int NIB_W = DATA_W / 2;

  logic             mode_q, phase;
  logic [NIB_W-1:0] hi_q;
  logic             mode_chg, last_part;

  assign mode_chg  = mode4_i != mode_q;
  assign last_part = !mode_q || phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      phase      <= 1'b0;
      hi_q       <= '0;
      wr_valid_o <= 1'b0;
      wr_sel_o   <= 1'b0;
      wr_byte_o  <= '0;
      rd_req_o   <= 1'b0;
    end else begin
      mode_q     <= mode4_i;
      wr_valid_o <= 1'b0;
      rd_req_o   <= 1'b0;
      if (mode_chg) begin
        phase <= 1'b0;  // collision: completing transfer is dropped
      end else if (fall_i) begin
        if (mode_q) phase <= ~phase;
        if (mode_q && !phase) hi_q <= data_i[DATA_W-1 -: NIB_W];
        if (last_part) begin
          if (!rnw_i) begin
            wr_valid_o <= 1'b1;
            wr_sel_o   <= rsel_i;
            wr_byte_o  <= mode_q ? {hi_q, data_i[DATA_W-1 -: NIB_W]} : data_i;
          end else if (rsel_i == lcd_hif_pkg::SEL_DATA) begin
            rd_req_o <= 1'b1;
          end
        end
      end
    end
  end

  assign mode_q_o = mode_q;
  assign phase_o  = phase;

  a_r2_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  a_r6_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_o && rd_req_o));
  a_r9_mode_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (!phase && !wr_valid_o && !rd_req_o));
  a_r7_second_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_valid_o || rd_req_o) && mode_q) |-> (!phase && $past(phase)));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> ($stable(wr_byte_o) && $stable(wr_sel_o)));
endmodule

// File: rtl/lcd_hif_rdmux.sv
module lcd_hif_rdmux #(
  parameter int DATA_W = 8
) (
  input  logic                oe_i,
  input  logic                rsel_i,
  input  logic                mode4_i,
  input  logic                phase_i,
  input  logic                busy_i,
  input  logic [DATA_W-2:0]   addr_ctr_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic [DATA_W-1:0]   db_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam int LANES = DATA_W / NIB_W;

  logic [DATA_W-1:0] src;
  assign src = rsel_i ? rd_data_i : {busy_i, addr_ctr_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NIB_W-1:0] lane;
    always_comb begin
      lane = '0;
      if (oe_i) begin
        if (!mode4_i) lane = src[g*NIB_W +: NIB_W];
        else if (g == LANES-1)
          lane = phase_i ? src[NIB_W-1:0] : src[DATA_W-1 -: NIB_W];
      end
    end
    assign db_o[g*NIB_W +: NIB_W] = lane;
  end
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode4_i,
  input  logic              strobe_i,
  input  logic              rsel_i,
  input  logic              rnw_i,
  input  logic [DATA_W-1:0] db_i,
  output logic [DATA_W-1:0] db_o,
  output logic              db_oe_o,
  input  logic              busy_i,
  input  logic [DATA_W-2:0] addr_ctr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic              wr_sel_o,
  output logic [DATA_W-1:0] wr_byte_o,
  output logic              rd_req_o
);
  import lcd_hif_pkg::*;

  localparam int CTL_W    = $bits(bus_ctl_t);
  localparam int DATA_DLY = SYNC_STAGES + 1;

  bus_ctl_t          ctl_raw, ctl_cur, ctl_prv;
  logic [CTL_W-1:0]  ctl_cur_v;
  logic [DATA_W-1:0] data_prv;
  logic              fall, mode_q, phase;

  assign ctl_raw = '{strobe: strobe_i, rsel: rsel_i, rnw: rnw_i};

  lcd_hif_pipe #(.W(CTL_W), .DEPTH(SYNC_STAGES)) u_ctl_sync (
    .clk_i, .rst_ni, .d_i(ctl_raw), .q_o(ctl_cur_v)
  );
  assign ctl_cur = bus_ctl_t'(ctl_cur_v);

  // data delayed one stage more, aligned with ctl_prv
  lcd_hif_pipe #(.W(DATA_W), .DEPTH(DATA_DLY)) u_data_sync (
    .clk_i, .rst_ni, .d_i(db_i), .q_o(data_prv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_prv <= '0;
    else         ctl_prv <= ctl_cur;
  end

  assign fall = ctl_prv.strobe && !ctl_cur.strobe;

  lcd_hif_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk_i, .rst_ni,
    .mode4_i,
    .fall_i    (fall),
    .rnw_i     (ctl_prv.rnw),
    .rsel_i    (ctl_prv.rsel),
    .data_i    (data_prv),
    .mode_q_o  (mode_q),
    .phase_o   (phase),
    .wr_valid_o,
    .wr_sel_o,
    .wr_byte_o,
    .rd_req_o
  );

  assign db_oe_o = ctl_cur.strobe && ctl_cur.rnw;

  lcd_hif_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .oe_i      (db_oe_o),
    .rsel_i    (ctl_cur.rsel),
    .mode4_i   (mode_q),
    .phase_i   (phase),
    .busy_i,
    .addr_ctr_i,
    .rd_data_i,
    .db_o
  );

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_oe_o |-> (db_o == '0));
endmodule

// File: tb/tb_lcd_host_port.sv
module tb_lcd_host_port;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic       s;
    logic       rs;
    logic       rw;
    logic [7:0] d;
  } smp_t;

  logic       clk = 0, rst_ni = 0;
  logic       mode4 = 0, strobe = 0, rsel = 0, rnw = 0, busy = 0;
  logic [7:0] db_i = 0, rd_data = 0;
  logic [6:0] ac = 0;
  logic [7:0] db_o, wr_byte;
  logic       db_oe, wr_valid, wr_sel, rd_req;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  lcd_host_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode4_i(mode4), .strobe_i(strobe),
    .rsel_i(rsel), .rnw_i(rnw), .db_i(db_i), .db_o(db_o), .db_oe_o(db_oe),
    .busy_i(busy), .addr_ctr_i(ac), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_sel_o(wr_sel), .wr_byte_o(wr_byte),
    .rd_req_o(rd_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  smp_t h1 = '0, h2 = '0, h3 = '0;
  logic m_mode = 0, m_wv = 0, m_rr = 0, m_sel = 0;
  int   m_phase = 0;
  logic [3:0] m_hi = 0;
  logic [7:0] m_byte = 0;

  always @(posedge clk) begin
    logic fall, chg;
    logic [7:0] src, exp_db;
    logic exp_oe;
    if (!rst_ni) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_mode = 0; m_phase = 0; m_hi = 0; m_byte = 0; m_sel = 0;
      m_wv = 0; m_rr = 0;
    end else begin
      fall = h3.s && !h2.s;
      chg = 0;
      m_wv = 0; m_rr = 0;
      if (mode4 != m_mode) begin
        m_phase = 0; m_mode = mode4; chg = 1;
      end else if (fall) begin
        if (!m_mode || m_phase == 1) begin
          if (!h3.rw) begin
            m_wv = 1; m_sel = h3.rs;
            m_byte = m_mode ? {m_hi, h3.d[7:4]} : h3.d;
          end else if (h3.rs) m_rr = 1;
        end
        if (m_mode) begin
          if (m_phase == 0) begin m_hi = h3.d[7:4]; m_phase = 1; end
          else m_phase = 0;
        end
      end
      h3 = h2; h2 = h1; h1 = '{s: strobe, rs: rsel, rw: rnw, d: db_i};
      #(CLK_P/4);
      exp_oe = h2.s && h2.rw;
      src = h2.rs ? rd_data : {busy, ac};
      if (!exp_oe) exp_db = 8'h00;
      else if (!m_mode) exp_db = src;
      else exp_db = {(m_phase == 1) ? src[3:0] : src[7:4], 4'h0};
      chk(chg ? "R9 wr_valid" : (m_mode ? "R7 wr_valid" : "R2 wr_valid"), wr_valid, m_wv);
      chk(chg ? "R9 rd_req" : (m_mode ? "R8 rd_req" : "R6 rd_req"), rd_req, m_rr);
      chk("R3 wr_sel", wr_sel, m_sel);
      chk(m_wv ? (m_mode ? "R7 wr_byte" : "R2 wr_byte") : "R11 wr_byte", wr_byte, m_byte);
      chk("R4 db_oe", db_oe, exp_oe);
      chk(!exp_oe ? "R10 db_o" : (m_mode ? "R8 db_o" : "R5 db_o"), db_o, exp_db);
    end
  end

  task automatic bus_cycle(input logic rw, input logic rs, input logic [7:0] d,
                           input bit flip);
    @(negedge clk);
    rnw = rw; rsel = rs; db_i = d;
    @(negedge clk);
    strobe = 1;
    repeat (4) @(negedge clk);
    strobe = 0;
    if (flip) begin
      repeat (2) @(negedge clk);
      mode4 = ~mode4;  // lands on the completion edge
      repeat (3) @(negedge clk);
    end else repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 db_oe", db_oe, 0);
    chk("R1 db_o", db_o, 0);
    chk("R1 wr_byte", wr_byte, 0);
    chk("R1 wr_sel", wr_sel, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    // byte mode
    busy = 1; ac = 7'h55; rd_data = 8'hC3;
    bus_cycle(0, 0, 8'h3C, 0);
    bus_cycle(0, 1, 8'hA5, 0);
    bus_cycle(1, 0, 8'hFF, 0);
    busy = 0; ac = 7'h12;
    bus_cycle(1, 0, 8'h00, 0);
    bus_cycle(1, 1, 8'h00, 0);
    bus_cycle(0, 1, 8'h00, 0);
    bus_cycle(0, 0, 8'hFF, 0);

    // nibble mode
    @(negedge clk); mode4 = 1;
    rd_data = 8'h9E; busy = 1; ac = 7'h2B;
    bus_cycle(0, 0, 8'h7B, 0);
    bus_cycle(0, 1, 8'h2C, 0);
    bus_cycle(1, 1, 8'h00, 0);
    bus_cycle(1, 1, 8'h00, 0);
    bus_cycle(1, 0, 8'h00, 0);
    bus_cycle(1, 0, 8'h00, 0);
    bus_cycle(0, 1, 8'hE1, 0);
    bus_cycle(0, 1, 8'h5F, 0);

    // collisions: mode change on completion edge
    bus_cycle(0, 1, 8'h40, 0);
    bus_cycle(0, 1, 8'h80, 1);   // nibble -> byte, dropped
    bus_cycle(0, 0, 8'h66, 0);
    bus_cycle(0, 1, 8'h99, 1);   // byte -> nibble, dropped
    bus_cycle(1, 1, 8'h00, 0);   // phase restarted: high half first
    bus_cycle(1, 1, 8'h00, 0);
    bus_cycle(0, 0, 8'hD0, 0);
    bus_cycle(0, 0, 8'h40, 0);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule